// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of interrupt request lines and a processor. Sources include program faults such as arithmetic overflow or division by zero, a timer, I/O devices, and hardware failures such as a memory parity error. The block captures each request as it arrives. It presents a single interrupt output and a vector to the processor. It tracks which priority levels are currently being serviced.

The block has two handling styles, chosen at run time by a mode input. In sequential mode, nothing new is signalled while any service is active. Captured requests wait and are offered one by one after each completion. In nested mode, a request of strictly higher priority interrupts the service in progress. Each end-of-interrupt retires the most urgent active level, so control falls back to the level that was preempted. Vector tables and context saving belong to the processor side.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `intOut` is low, `vecOut` is zero, and no request is pending or in service.
- R2: A request becomes pending only on a low-to-high transition of its line. A line held high after its request is acknowledged does not become pending again.
- R3: Line 0 has the highest priority, and the pending line with the lowest index wins. While `intOut` is high, `vecOut` equals `VEC_BASE` plus the winning index. While `intOut` is low, `vecOut` is zero.
- R4: `intAck` sampled high while `intOut` is high clears the winning line's pending bit and marks that level in service from the next cycle.
- R5: With `nestMode` low, `intOut` stays low while any level is in service. A waiting request is offered in the cycle after the last in-service level is retired.
- R6: With `nestMode` high, a pending line whose index is below the lowest in-service index raises `intOut`, so it preempts the active service.
- R7: With `nestMode` high, a pending line whose index is equal to or above the lowest in-service index stays pending and keeps `intOut` low.
- R8: `eoi` clears only the lowest-index in-service bit. Successive `eoi` pulses therefore return service to each preempted level in turn.
- R9: `intAck` while `intOut` is low has no effect. It changes neither the pending nor the in-service state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_LINES | Request lines; bit 0 is most urgent |
| nestMode | input | 1 | 1 = nested preemption, 0 = sequential handling |
| intAck | input | 1 | Processor acknowledge of the offered interrupt |
| eoi | input | 1 | End of service for the most urgent active level |
| intOut | output | 1 | Interrupt offered to the processor |
| vecOut | output | VEC_W | VEC_BASE plus the offered line index; zero when idle |

## Verification
`intOut` and `vecOut` are decoded from registered state only. A request edge, an acknowledge or an `eoi` applied before a clock edge therefore shows up in the outputs one cycle later. The outputs seen in a cycle reflect the state before that cycle's inputs take effect. The driver applies inputs on the falling edge and queues the outputs it expects for that same cycle, taken from a reference model of the requirements. The model's state then advances. The monitor compares the queued item one nanosecond after that falling edge. Every item therefore lands exactly one register stage after the stimulus that caused it.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
  // strobes issued by control, applied by the datapath
  typedef struct packed {
    logic grant;   // move winning pending line into service
    logic retire;  // drop most urgent in-service level
  } ctlStrobe_t;
endpackage

// File: rtl/nest_irq_datapath.sv
module nest_irq_datapath
  import nest_irq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqIn,
  input  ctlStrobe_t           strobe,
  output logic                 winValid,
  output logic [IDX_W-1:0]     winIdx,
  output logic                 topValid,
  output logic [IDX_W-1:0]     topIdx,
  output logic [NUM_LINES-1:0] inService
);
  logic [NUM_LINES-1:0] reqPrev, pending, riseMask, grantMask, retireMask;

  assign riseMask   = reqIn & ~reqPrev;
  assign grantMask  = strobe.grant  ? (NUM_LINES'(1) << winIdx) : '0;
  assign retireMask = strobe.retire ? (NUM_LINES'(1) << topIdx) : '0;

  // lowest set index wins for both vectors
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    topValid = 1'b0;
    topIdx   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pending[i]) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(i);
      end
      if (inService[i]) begin
        topValid = 1'b1;
        topIdx   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPrev   <= '0;
      pending   <= '0;
      inService <= '0;
    end else begin
      reqPrev   <= reqIn;
      pending   <= (pending & ~grantMask) | riseMask;
      inService <= (inService & ~retireMask) | grantMask;
    end
  end
endmodule

// File: rtl/nest_irq_control.sv
module nest_irq_control
  import nest_irq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 8,
  parameter int VEC_BASE  = 32,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             winValid,
  input  logic [IDX_W-1:0] winIdx,
  input  logic             topValid,
  input  logic [IDX_W-1:0] topIdx,
  input  logic             nestMode,
  input  logic             intAck,
  input  logic             eoi,
  output logic             intOut,
  output logic [VEC_W-1:0] vecOut,
  output ctlStrobe_t       strobe
);
  logic mayPreempt;

  assign mayPreempt    = nestMode && (winIdx < topIdx);
  assign intOut        = winValid && (!topValid || mayPreempt);
  assign vecOut        = intOut ? (VEC_W'(VEC_BASE) + VEC_W'(winIdx)) : '0;
  assign strobe.grant  = intAck && intOut;
  assign strobe.retire = eoi && topValid;
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nest_irq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 8,
  parameter int VEC_BASE  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic                 nestMode,
  input  logic                 intAck,
  input  logic                 eoi,
  output logic                 intOut,
  output logic [VEC_W-1:0]     vecOut
);
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  ctlStrobe_t           strobe;
  logic                 winValid, topValid;
  logic [IDX_W-1:0]     winIdx, topIdx;
  logic [NUM_LINES-1:0] inService;

  nest_irq_datapath #(.NUM_LINES(NUM_LINES)) dp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .strobe(strobe),
    .winValid(winValid), .winIdx(winIdx), .topValid(topValid),
    .topIdx(topIdx), .inService(inService)
  );

  nest_irq_control #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) ctl (
    .winValid(winValid), .winIdx(winIdx), .topValid(topValid), .topIdx(topIdx),
    .nestMode(nestMode), .intAck(intAck), .eoi(eoi),
    .intOut(intOut), .vecOut(vecOut), .strobe(strobe)
  );
endmodule

// File: rtl/nest_irq_checker.sv
module nest_irq_checker #(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 8,
  parameter int VEC_BASE  = 32,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 nestMode,
  input logic                 intAck,
  input logic                 eoi,
  input logic                 intOut,
  input logic [VEC_W-1:0]     vecOut,
  input logic [NUM_LINES-1:0] inService
);
  logic [VEC_W-1:0] vecOff;
  assign vecOff = vecOut - VEC_W'(VEC_BASE);

  // R3: an offered vector lies inside the line range
  assert_vec_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> (vecOff < VEC_W'(NUM_LINES)));

  // R4: acknowledged line is in service next cycle
  assert_ack_enters_service_R4: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intOut) |=> inService[$past(vecOff[IDX_W-1:0])]);

  // R5: sequential mode offers nothing during service
  assert_seq_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!nestMode && (inService != '0)) |-> !intOut);

  // R8: eoi without grant removes exactly one active level
  assert_eoi_one_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    (eoi && !intAck && (inService != '0)) |=>
      ($countones(inService) + 1 == $past($countones(inService))));

  // R9: stray acknowledge leaves service state unchanged
  assert_stray_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !intOut && !eoi) |=> $stable(inService));
endmodule

bind nest_irq_ctrl nest_irq_checker #(
  .NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) chk (
  .clk(clk), .rstN(rstN), .nestMode(nestMode), .intAck(intAck), .eoi(eoi),
  .intOut(intOut), .vecOut(vecOut), .inService(inService)
);

// File: tb/nest_irq_ctrl_test.sv
`timescale 1ns/1ps
module nest_irq_ctrl_test;
  localparam int LINES = 8;
  localparam int BASE  = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] reqIn = '0;
  logic       nestMode = 1'b0, intAck = 1'b0, eoi = 1'b0;
  logic       intOut;
  logic [7:0] vecOut;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { logic expInt; logic [7:0] expVec; string tag; } item_t;
  item_t sbq[$];

  // reference state
  logic [7:0] mPend = '0, mPrev = '0, mIsr = '0;

  always #2 clk = ~clk;  // 250 MHz

  nest_irq_ctrl #(.NUM_LINES(LINES), .VEC_W(8), .VEC_BASE(BASE)) uut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .nestMode(nestMode),
    .intAck(intAck), .eoi(eoi), .intOut(intOut), .vecOut(vecOut)
  );

  function automatic int lowestSet(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  // driver: apply inputs, queue outputs due this cycle, advance model
  task automatic step(logic [7:0] req, logic ack, logic endInt, logic nest, string tag);
    item_t it;
    int w, t;
    logic elig;
    @(negedge clk);
    reqIn = req; intAck = ack; eoi = endInt; nestMode = nest;
    w = lowestSet(mPend);
    t = lowestSet(mIsr);
    elig = (w < 8) && ((t == 8) || (nest && (w < t)));
    it.expInt = elig;
    it.expVec = elig ? 8'(BASE + w) : 8'd0;
    it.tag = tag;
    sbq.push_back(it);
    if (endInt && t < 8) mIsr[t] = 1'b0;
    if (ack && elig) begin mPend[w] = 1'b0; mIsr[w] = 1'b1; end
    mPend = mPend | (req & ~mPrev);
    mPrev = req;
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    #1;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (intOut !== it.expInt || vecOut !== it.expVec) begin
        fails++;
        $display("FAIL %s: intOut=%0b vecOut=%0h expected intOut=%0b vecOut=%0h",
                 it.tag, intOut, vecOut, it.expInt, it.expVec);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(8'h00, 0, 0, 0, "R1");            // reset state
    step(8'h00, 1, 0, 0, "R9");            // stray ack
    step(8'h00, 0, 0, 0, "R9");
    // sequential mode
    step(8'h24, 0, 0, 0, "R2");            // edges on 2 and 5
    step(8'h24, 0, 0, 0, "R3");            // line 2 offered, vec 0x22
    step(8'h24, 1, 0, 0, "R4");            // grant 2
    step(8'h24, 0, 0, 0, "R5");            // held while in service
    step(8'h24, 1, 0, 0, "R9");            // ack ignored, no intOut
    step(8'h24, 0, 1, 0, "R5");            // retire 2
    step(8'h24, 0, 0, 0, "R5");            // line 5 offered
    step(8'h24, 1, 0, 0, "R4");            // grant 5
    step(8'h24, 0, 1, 0, "R2");            // retire 5
    step(8'h24, 0, 0, 0, "R2");            // held levels do not re-pend
    step(8'h00, 0, 0, 1, "R2");
    // nested mode
    step(8'h10, 0, 0, 1, "R6");            // edge on 4
    step(8'h10, 1, 0, 1, "R6");            // grant 4
    step(8'h50, 0, 0, 1, "R7");            // edge on 6, lower priority
    step(8'h40, 0, 0, 1, "R7");
    step(8'h50, 0, 0, 1, "R7");            // new edge on 4, equal priority
    step(8'h52, 0, 0, 1, "R7");            // edge on 1
    step(8'h52, 1, 0, 1, "R6");            // preempt: grant 1
    step(8'h52, 0, 0, 1, "R7");            // 4 and 6 held
    step(8'h52, 0, 1, 1, "R8");            // retire 1, back to level 4
    step(8'h52, 0, 0, 1, "R8");            // 4 still equal to active level
    step(8'h52, 0, 1, 1, "R8");            // retire 4
    step(8'h52, 0, 0, 1, "R8");            // pending 4 offered again
    step(8'h52, 1, 1, 0, "R5");
    step(8'h00, 0, 1, 0, "R5");
    step(8'h00, 0, 1, 0, "R5");
    // mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int n = 0; n < 120; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[7:0], lfsr[8], lfsr[9] & lfsr[11], lfsr[12], "R3");
    end
    step(8'h00, 0, 0, 0, "R3");
    @(negedge clk); #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule